// File: doc/BRIEF.md
# Packet Time-Stamp Capture Unit

This block records the value of a free-running precision time counter at packet boundaries on both directions of an Ethernet port. A receive start-of-frame strobe copies the time into a receive capture register. A transmit start-of-packet strobe copies the time and the packet's identifier into one of two transmit slots, but only for a packet marked for stamping or while stamping of every packet is selected. Nothing is captured while the time counter is disabled.

Each capture sets a sticky event bit. A mask selects which event bits drive the interrupt line. Transmit slots are filled in alternation and are released by a per-slot clear strobe. When both slots are still unread, a new stamp overwrites the older one and raises an overflow event.

A byte stream with a valid/ready handshake can carry the captured time into the packet's padding area. It sends 8 bytes, most significant first, and tags each byte with its byte offset from the start of the pad area and with its direction.

Top module: `pkt_tstamp_capture`

## Requirements
- R1: While `tmr_en_i` is 0, no strobe changes `rx_ts_o`, the transmit slots, the event bits or the byte stream.
- R2: When `tmr_en_i`, `rx_stamp_en_i` and `rx_sof_i` are all 1 at a clock edge, `rx_ts_o` equals the `time_i` of that edge from the next cycle on. Otherwise `rx_ts_o` holds its value.
- R3: A transmit capture happens at a clock edge where `tmr_en_i` and `tx_sop_i` are both 1 and at least one of `tx_flag_i` or `tx_stamp_all_i` is 1. It stores `tx_id_i` and `time_i` in slot s. Slot s is read at `tx_id_o[s*ID_W +: ID_W]` and `tx_ts_o[s*TIME_W +: TIME_W]`, and `tx_vld_o[s]` is set.
- R4: The target slot is chosen as follows. If exactly one slot is free, the capture goes into that slot. If both slots are free, or both are full, it goes into the slot after the one written last; slot 0 is the first after reset. A capture into two full slots overwrites the older entry and sets event bit 2 (overflow).
- R5: A 1 on `slot_clr_i[s]` clears `tx_vld_o[s]`. The clear is applied before the slot choice of the same cycle, so a capture in that cycle may refill the slot.
- R6: The event bits in `evt_o` are bit 0 for a receive capture, bit 1 for a transmit capture and bit 2 for an overflow. They are sticky and are cleared by writing 1 to the matching bit of `evt_clr_i`. If a set and a clear of the same bit happen in the same cycle, the set wins.
- R7: `irq_o` is 1 exactly when some bit is set in both `evt_o` and `irq_mask_i`.
- R8: When `inline_en_i` is 1, `pad_len_i` is at least 8 and the stream is idle, a receive capture starts a stream of 8 bytes of the captured time, most significant byte first. The bytes carry offsets 0 to 7 and `ins_dir_o`=0. With `pad_len_i` below 8, no stream is started.
- R9: Under the same conditions, a transmit capture streams its time with offsets 16 to 23 and `ins_dir_o`=1. When a receive stream and a transmit stream could both start in the same cycle, the receive stream is started.
- R10: A byte is held, with all of its tags unchanged, until it is accepted with `ins_valid_o` and `ins_ready_i` both 1. `ins_last_o` marks the eighth byte. A capture that arrives while the stream is busy is still stored but is not streamed.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | TIME_W | Current precision time |
| tmr_en_i | input | 1 | Global time counter enable |
| rx_stamp_en_i | input | 1 | Receive stamping enable |
| tx_stamp_all_i | input | 1 | Stamp every transmitted packet |
| inline_en_i | input | 1 | Emit stamps as padding bytes |
| pad_len_i | input | 8 | Configured receive pad length in bytes |
| rx_sof_i | input | 1 | Receive start-of-frame strobe |
| tx_sop_i | input | 1 | Transmit start strobe |
| tx_flag_i | input | 1 | Per-packet stamp request |
| tx_id_i | input | ID_W | Packet identifier |
| slot_clr_i | input | 2 | Per-slot read release |
| evt_clr_i | input | 3 | Write-1-to-clear for event bits |
| irq_mask_i | input | 3 | Interrupt mask per event bit |
| ins_ready_i | input | 1 | Stream sink ready |
| rx_ts_o | output | TIME_W | Receive capture |
| tx_id_o | output | 2*ID_W | Slot identifiers |
| tx_ts_o | output | 2*TIME_W | Slot stamps |
| tx_vld_o | output | 2 | Slot holds an unread entry |
| evt_o | output | 3 | Sticky event bits |
| irq_o | output | 1 | Interrupt |
| ins_valid_o | output | 1 | Stream byte valid |
| ins_data_o | output | 8 | Stream byte |
| ins_last_o | output | 1 | Final byte of stamp |
| ins_ofs_o | output | 8 | Byte offset in pad area |
| ins_dir_o | output | 1 | 0 receive, 1 transmit |

## Verification
The bench drives strobes with the timer disabled, with stamping disabled and with each enable on, so that gating can be told apart from capture. Runs of three or more transmit captures, with slot releases in between and in the same cycle as a capture, separate free-slot placement, alternation and overwrite of the oldest entry. The sink's ready line runs both steady and stalling, and some captures overlap a busy stream or occur together with a capture in the other direction. These cases show holding, dropped streams and receive priority. A behavioural model, built from queues, predicts every output and is compared with the design in every cycle.

// File: rtl/pkt_ts_pkg.sv
package pkt_ts_pkg;
  localparam int EVT_W   = 3;
  localparam int EVT_RX  = 0;
  localparam int EVT_TX  = 1;
  localparam int EVT_OVF = 2;
  localparam logic [7:0] MIN_PAD    = 8'd8;
  localparam logic [7:0] TX_PAD_OFS = 8'd16;
  localparam logic [7:0] RX_PAD_OFS = 8'd0;
  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} ts_dir_e;
endpackage

// File: rtl/ts_slot_pair.sv
module ts_slot_pair #(
  parameter int TIME_W = 64,
  parameter int ID_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ID_W-1:0]     id_i,
  input  logic [TIME_W-1:0]   ts_i,
  input  logic [1:0]          clr_i,
  output logic [1:0]          vld_o,
  output logic [2*ID_W-1:0]   ids_o,
  output logic [2*TIME_W-1:0] tss_o,
  output logic                ovf_o
);
  logic [1:0] vld_q, vld_eff;
  logic       ptr_q, tgt;

  assign vld_eff = vld_q & ~clr_i;

  always_comb begin
    case (vld_eff)
      2'b01:   tgt = 1'b1;
      2'b10:   tgt = 1'b0;
      default: tgt = ptr_q;
    endcase
  end

  assign ovf_o = wr_i & (&vld_eff);
  assign vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= 1'b0;
    end else begin
      vld_q <= vld_eff | ({1'b0, wr_i} << tgt);
      if (wr_i) ptr_q <= ~tgt;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [ID_W-1:0]   id_q;
    logic [TIME_W-1:0] ts_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q <= '0;
        ts_q <= '0;
      end else if (wr_i && (tgt == 1'(s))) begin
        id_q <= id_i;
        ts_q <= ts_i;
      end
    end
    assign ids_o[s*ID_W +: ID_W]     = id_q;
    assign tss_o[s*TIME_W +: TIME_W] = ts_q;
  end

  assert_wr_fills_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (vld_q != 2'b00));
endmodule

// File: rtl/ts_byte_emit.sv
module ts_byte_emit #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] word_i,
  input  logic [7:0]        base_i,
  input  logic              dir_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic              last_o,
  output logic [7:0]        ofs_o,
  output logic              dir_o
);
  localparam int NB    = TIME_W / 8;
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  logic              busy_q, dir_q;
  logic [IDX_W-1:0]  cnt_q;
  logic [TIME_W-1:0] sh_q;
  logic [7:0]        base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      base_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sh_q   <= word_i;
        cnt_q  <= '0;
        base_q <= base_i;
        dir_q  <= dir_i;
      end
    end else if (ready_i) begin
      if (cnt_q == LAST_IDX) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        sh_q  <= sh_q << 8;
      end
    end
  end

  assign valid_o = busy_q;
  assign data_o  = sh_q[TIME_W-1 -: 8];
  assign last_o  = busy_q && (cnt_q == LAST_IDX);
  assign ofs_o   = base_q + 8'(cnt_q);
  assign dir_o   = dir_q;

  assert_hold_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(ofs_o) && $stable(dir_o)));
  assert_end_after_last_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> !valid_o);
endmodule

// File: rtl/pkt_tstamp_capture.sv
module pkt_tstamp_capture
  import pkt_ts_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ID_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TIME_W-1:0]   time_i,
  input  logic                tmr_en_i,
  input  logic                rx_stamp_en_i,
  input  logic                tx_stamp_all_i,
  input  logic                inline_en_i,
  input  logic [7:0]          pad_len_i,
  input  logic                rx_sof_i,
  input  logic                tx_sop_i,
  input  logic                tx_flag_i,
  input  logic [ID_W-1:0]     tx_id_i,
  input  logic [1:0]          slot_clr_i,
  input  logic [EVT_W-1:0]    evt_clr_i,
  input  logic [EVT_W-1:0]    irq_mask_i,
  input  logic                ins_ready_i,
  output logic [TIME_W-1:0]   rx_ts_o,
  output logic [2*ID_W-1:0]   tx_id_o,
  output logic [2*TIME_W-1:0] tx_ts_o,
  output logic [1:0]          tx_vld_o,
  output logic [EVT_W-1:0]    evt_o,
  output logic                irq_o,
  output logic                ins_valid_o,
  output logic [7:0]          ins_data_o,
  output logic                ins_last_o,
  output logic [7:0]          ins_ofs_o,
  output logic                ins_dir_o
);
  logic              rx_cap, tx_cap, rx_inl, ovf;
  logic [TIME_W-1:0] rx_ts_q;
  logic [EVT_W-1:0]  evt_q, evt_set;

  assign rx_cap = tmr_en_i & rx_sof_i & rx_stamp_en_i;
  assign tx_cap = tmr_en_i & tx_sop_i & (tx_flag_i | tx_stamp_all_i);
  assign rx_inl = rx_cap & (pad_len_i >= MIN_PAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_ts_q <= '0;
    else if (rx_cap) rx_ts_q <= time_i;
  end

  ts_slot_pair #(.TIME_W(TIME_W), .ID_W(ID_W)) u_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (tx_cap),
    .id_i   (tx_id_i),
    .ts_i   (time_i),
    .clr_i  (slot_clr_i),
    .vld_o  (tx_vld_o),
    .ids_o  (tx_id_o),
    .tss_o  (tx_ts_o),
    .ovf_o  (ovf)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EVT_RX]  = rx_cap;
    evt_set[EVT_TX]  = tx_cap;
    evt_set[EVT_OVF] = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~evt_clr_i) | evt_set;
  end

  assign evt_o   = evt_q;
  assign irq_o   = |(evt_q & irq_mask_i);
  assign rx_ts_o = rx_ts_q;

  ts_byte_emit #(.TIME_W(TIME_W)) u_emit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (inline_en_i & (rx_inl | tx_cap)),
    .word_i  (time_i),
    .base_i  (rx_inl ? RX_PAD_OFS : TX_PAD_OFS),
    .dir_i   (rx_inl ? DIR_RX : DIR_TX),
    .ready_i (ins_ready_i),
    .valid_o (ins_valid_o),
    .data_o  (ins_data_o),
    .last_o  (ins_last_o),
    .ofs_o   (ins_ofs_o),
    .dir_o   (ins_dir_o)
  );

  assert_timer_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_en_i |=> $stable(rx_ts_o));
  assert_rx_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_en_i && rx_sof_i && rx_stamp_en_i) |=> (rx_ts_o == $past(time_i)));
  assert_rx_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_en_i && rx_sof_i && rx_stamp_en_i) |=> evt_o[EVT_RX]);
endmodule

// File: tb/pkt_tstamp_capture_test.sv
`timescale 1ns/1ps
module pkt_tstamp_capture_test;
  localparam int TW = 64;
  localparam int IW = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic [TW-1:0] time_i = 64'h0123_4567_89AB_0000;
  logic tmr_en = 0, rx_en = 0, tx_all = 0, inl_en = 0;
  logic [7:0] pad_len = 0;
  logic rx_sof = 0, tx_sop = 0, tx_flag = 0;
  logic [IW-1:0] tx_id = 0;
  logic [1:0] slot_clr = 0;
  logic [2:0] evt_clr = 0, irq_mask = 0;
  logic ins_ready = 1'b1;
  int   rdy_mode = 0;

  logic [TW-1:0]   rx_ts_o;
  logic [2*IW-1:0] tx_id_o;
  logic [2*TW-1:0] tx_ts_o;
  logic [1:0]      tx_vld_o;
  logic [2:0]      evt_o;
  logic            irq_o, ins_valid_o, ins_last_o, ins_dir_o;
  logic [7:0]      ins_data_o, ins_ofs_o;

  pkt_tstamp_capture #(.TIME_W(TW), .ID_W(IW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .time_i(time_i), .tmr_en_i(tmr_en),
    .rx_stamp_en_i(rx_en), .tx_stamp_all_i(tx_all), .inline_en_i(inl_en),
    .pad_len_i(pad_len), .rx_sof_i(rx_sof), .tx_sop_i(tx_sop), .tx_flag_i(tx_flag),
    .tx_id_i(tx_id), .slot_clr_i(slot_clr), .evt_clr_i(evt_clr), .irq_mask_i(irq_mask),
    .ins_ready_i(ins_ready), .rx_ts_o(rx_ts_o), .tx_id_o(tx_id_o), .tx_ts_o(tx_ts_o),
    .tx_vld_o(tx_vld_o), .evt_o(evt_o), .irq_o(irq_o), .ins_valid_o(ins_valid_o),
    .ins_data_o(ins_data_o), .ins_last_o(ins_last_o), .ins_ofs_o(ins_ofs_o),
    .ins_dir_o(ins_dir_o)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit run_cmp = 0;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // reference model
  logic [TW-1:0] m_rx;
  logic [IW-1:0] m_id [2];
  logic [TW-1:0] m_ts [2];
  logic [1:0]    m_vld, v;
  logic [2:0]    m_evt, ev;
  bit            m_ptr, t, idle, rxc, txc, m_dir;
  int            m_base;
  logic [7:0]    m_q[$];

  task automatic m_start(logic [TW-1:0] w, int base, bit dir);
    for (int k = 0; k < 8; k++) m_q.push_back(w[TW-1-8*k -: 8]);
    m_base = base;
    m_dir  = dir;
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rx = '0; m_id[0] = '0; m_id[1] = '0; m_ts[0] = '0; m_ts[1] = '0;
      m_vld = '0; m_evt = '0; m_ptr = 0; m_q.delete(); m_base = 0; m_dir = 0;
    end else begin
      cyc++;
      idle = (m_q.size() == 0);
      if (!idle && ins_ready) void'(m_q.pop_front());
      rxc = tmr_en && rx_sof && rx_en;
      txc = tmr_en && tx_sop && (tx_flag || tx_all);
      ev = m_evt & ~evt_clr;
      if (rxc) begin m_rx = time_i; ev[0] = 1'b1; end
      v = m_vld & ~slot_clr;
      if (txc) begin
        ev[1] = 1'b1;
        if (v == 2'b11) begin t = m_ptr; ev[2] = 1'b1; end
        else if (v == 2'b01) t = 1;
        else if (v == 2'b10) t = 0;
        else t = m_ptr;
        m_id[t] = tx_id; m_ts[t] = time_i; v[t] = 1'b1; m_ptr = !t;
      end
      m_vld = v; m_evt = ev;
      if (idle && inl_en) begin
        if (rxc && pad_len >= 8) m_start(time_i, 0, 0);
        else if (txc) m_start(time_i, 16, 1);
      end
    end
  end

  always @(negedge clk) begin
    time_i <= time_i + 64'd10;
    ins_ready <= (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    if (rst_ni && run_cmp) begin
      #1;
      chk("R2 rx stamp", 128'(rx_ts_o), 128'(m_rx));
      chk("R3 slot ids", 128'(tx_id_o), 128'({m_id[1], m_id[0]}));
      chk("R3 slot stamps", tx_ts_o, {m_ts[1], m_ts[0]});
      chk("R4 R5 slot valid", 128'(tx_vld_o), 128'(m_vld));
      chk("R6 events", 128'(evt_o), 128'(m_evt));
      chk("R7 irq", 128'(irq_o), 128'(|(m_evt & irq_mask)));
      chk("R10 stream valid", 128'(ins_valid_o), 128'(m_q.size() != 0));
      if (m_q.size() != 0) begin
        chk(m_dir ? "R9 tx byte" : "R8 rx byte", 128'(ins_data_o), 128'(m_q[0]));
        chk(m_dir ? "R9 tx offset" : "R8 rx offset", 128'(ins_ofs_o),
            128'(m_base + 8 - m_q.size()));
        chk("R9 direction", 128'(ins_dir_o), 128'(m_dir));
        chk("R10 last", 128'(ins_last_o), 128'(m_q.size() == 1));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_pulse();
    @(negedge clk); rx_sof = 1;
    @(negedge clk); rx_sof = 0;
  endtask

  task automatic tx_pulse(logic [IW-1:0] id, logic flag, logic [1:0] clr);
    @(negedge clk); tx_sop = 1; tx_flag = flag; tx_id = id; slot_clr = clr;
    @(negedge clk); tx_sop = 0; tx_flag = 0; slot_clr = 0;
  endtask

  initial begin
    step(3);
    #1;
    chk("R11 reset rx", 128'(rx_ts_o), 128'(0));
    chk("R11 reset slots", 128'({tx_vld_o, evt_o, irq_o, ins_valid_o}), 128'(0));
    @(negedge clk); rst_ni = 1; run_cmp = 1;
    // R1: timer disabled
    rx_en = 1; tx_all = 1; inl_en = 1; pad_len = 8;
    rx_pulse(); tx_pulse(16'h00AA, 1, 0);
    step(1); #1;
    chk("R1 gated events", 128'({evt_o, tx_vld_o, ins_valid_o}), 128'(0));
    tx_all = 0; inl_en = 0; rx_en = 0;
    tmr_en = 1;
    rx_pulse();                       // R2 stamping off
    rx_en = 1;
    rx_pulse();                       // R2 capture
    inl_en = 1; pad_len = 4;
    rx_pulse();                       // R8 no stream with short pad
    step(2);
    pad_len = 8; rdy_mode = 1;
    rx_pulse();                       // R8 stream with stalls
    step(16);
    rdy_mode = 0;
    tx_pulse(16'h0011, 0, 0);         // R3 not flagged
    tx_pulse(16'h0011, 1, 0);         // R3 slot 0
    tx_pulse(16'h0022, 1, 0);         // R10 busy: stored only
    step(10);
    tx_pulse(16'h0033, 1, 0);         // R4 overflow
    step(10); #1;
    chk("R4 overflow flag", 128'(evt_o[2]), 128'(1));
    tx_pulse(16'h0044, 1, 2'b11);     // R5 clear both, refill
    tx_pulse(16'h0055, 1, 2'b10);     // R5 clear with capture
    step(10);
    @(negedge clk); rx_sof = 1; tx_sop = 1; tx_flag = 1; tx_id = 16'h0066;  // R9 priority
    @(negedge clk); rx_sof = 0; tx_sop = 0; tx_flag = 0;
    step(10);
    irq_mask = 3'b010; step(2);
    @(negedge clk); evt_clr = 3'b111; tx_sop = 1; tx_flag = 1; tx_id = 16'h0077; // R6 set wins
    @(negedge clk); evt_clr = 0; tx_sop = 0; tx_flag = 0;
    step(10);
    @(negedge clk); evt_clr = 3'b111;
    @(negedge clk); evt_clr = 0; irq_mask = 3'b111;
    step(2);
    tx_all = 1; rdy_mode = 1;
    tx_pulse(16'h0088, 0, 0);         // R3 stamp all
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      rx_sof   = (i % 5 == 0);
      tx_sop   = (i % 7 == 3);
      tx_flag  = (i % 2 == 0);
      tx_id    = 16'(i);
      slot_clr = 2'(i % 4);
      evt_clr  = 3'(i % 8 == 6 ? 7 : 0);
      irq_mask = 3'(i % 8);
      pad_len  = (i % 3 == 0) ? 8'd7 : 8'd12;
    end
    @(negedge clk); rx_sof = 0; tx_sop = 0; slot_clr = 0; evt_clr = 0;
    step(30);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule